// File: doc/BRIEF.md
# Timed Test Coprocessor

This block is a validation coprocessor for exercising a processor core's coprocessor handshake and interrupt paths. It holds a bank of sixteen 32-bit registers. The issuing core writes these registers with move-to transfers and reads them with move-from transfers. Each transfer is addressed by a four-bit index taken from the instruction word.

Data-operation commands use the registers in a different way. The command field of the instruction selects an action, and the operand index selects the register the action reads from or writes to. The actions are:

- stall the issuer for a number of cycles held in a register;
- arm a delayed request on the fast or the normal interrupt line;
- drop either request line back high;
- write the present value of a free-running cycle counter into a register.

Busy and done show the command handshake. The two interrupt lines are active low. A test program can therefore build stall and interrupt scenarios with exact cycle timing.

Top module: `timed_test_copro`

## Requirements
- R1: While reset is held and just after it is released, the following hold: every register reads zero, busy, done and refused are low, and both interrupt lines are high.
- R2: A move-to pulse writes the write data into the register indexed by instruction bits 19:16. The read data always shows, without a clock delay, the register indexed by instruction bits 19:16.
- R3: Command code 0 (bits 23:20) reads a count N from the register indexed by bits 3:0. If N is non-zero, busy is high for exactly the N cycles after the accepting clock edge, and done is high for the single cycle that follows. If N is zero, busy never rises and done is high for the single cycle after the accepting edge.
- R4: Command code 1 reads a delay D from the operand register. The fast line goes low after the D-th clock edge following the accepting edge; when D is zero it goes low after the accepting edge itself. The line then stays low until it is released.
- R5: Command code 2 does the same as R4, but for the normal interrupt line.
- R6: Command codes 3 and 4 drive the fast and normal line high, respectively, after the accepting edge, and cancel any delay still pending on that line. A release accepted on the same edge at which that line's delay would expire leaves the line high.
- R7: A new code 1 or code 2 command replaces any delay still pending on that line. The new delay alone sets when the line falls.
- R8: A free-running counter is zero in reset and adds one on every clock edge. Command code 5 writes the counter value held during the accepting cycle into the operand register. That value equals the number of clock edges since reset was released. If a move-to writes the same register on the same edge, the capture wins.
- R9: Command codes 6 to 15 are refused. Refused is high for one cycle after the accepting edge, done stays low, and neither the registers nor the interrupt lines change.
- R10: A command presented while busy is high is ignored: it gives no done, no refused and no effect on the lines. Moves still work while busy is high.
- R11: Command codes 1 to 5 raise done for the single cycle after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_instr | input | 32 | Instruction word: command code 23:20, move index 19:16, operand index 3:0 |
| mv_to_valid | input | 1 | Move-to strobe, writes mv_wdata |
| mv_wdata | input | 32 | Move-to data |
| cmd_valid | input | 1 | Data-operation command strobe |
| mv_rdata | output | 32 | Move-from data, the register indexed by bits 19:16 |
| busy | output | 1 | Stall in progress |
| done | output | 1 | One-cycle completion pulse |
| refused | output | 1 | One-cycle pulse for an illegal command code |
| fiq_n | output | 1 | Fast interrupt request, active low |
| irq_n | output | 1 | Normal interrupt request, active low |

## Verification
Two events can land on the same edge for one interrupt line: its delay running out, and a release command for that line. The bench arms the fast line with a delay of two. It then times a release so that the release is accepted on exactly the edge where the delay would expire. It judges the result by checking that the line never falls during the following cycles. Lengths and delays are swept over small ranges, and the bench compares the measured busy cycles and line latency against the programmed values. An overwrite of a pending delay, refused codes and commands issued while busy are also checked.

// File: rtl/tct_pkg.sv
package tct_pkg;
   localparam int INSTR_W  = 32;
   localparam int FIELD_W  = 4;
   localparam int CODE_LSB = 20;
   localparam int MOVE_LSB = 16;
   localparam int OPND_LSB = 0;

   localparam logic [FIELD_W-1:0] OP_STALL    = 4'd0;
   localparam logic [FIELD_W-1:0] OP_SET_FAST = 4'd1;
   localparam logic [FIELD_W-1:0] OP_SET_NORM = 4'd2;
   localparam logic [FIELD_W-1:0] OP_CLR_FAST = 4'd3;
   localparam logic [FIELD_W-1:0] OP_CLR_NORM = 4'd4;
   localparam logic [FIELD_W-1:0] OP_STAMP    = 4'd5;
   localparam logic [FIELD_W-1:0] OP_LAST     = OP_STAMP;
endpackage

// File: rtl/tct_regfile.sv
module tct_regfile #(
   parameter int DATA_W = 32,
   parameter int NREG   = 16,
   localparam int IDX_W = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mv_we,
   input  logic [IDX_W-1:0]  mv_idx,
   input  logic [DATA_W-1:0] mv_data,
   input  logic              cap_we,
   input  logic [IDX_W-1:0]  cap_idx,
   input  logic [DATA_W-1:0] cap_data,
   input  logic [IDX_W-1:0]  rd_a_idx,
   output logic [DATA_W-1:0] rd_a,
   input  logic [IDX_W-1:0]  rd_b_idx,
   output logic [DATA_W-1:0] rd_b
);
   logic [DATA_W-1:0] regs [NREG];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) regs[i] <= '0;
      end else begin
         for (int i = 0; i < NREG; i++) begin
            if (cap_we && cap_idx == IDX_W'(i))
               regs[i] <= cap_data;
            else if (mv_we && mv_idx == IDX_W'(i))
               regs[i] <= mv_data;
         end
      end
   end

   assign rd_a = regs[rd_a_idx];
   assign rd_b = regs[rd_b_idx];

   assert_move_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mv_we && !(cap_we && cap_idx == mv_idx)) |=> regs[$past(mv_idx)] == $past(mv_data));

   assert_capture_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cap_we |=> regs[$past(cap_idx)] == $past(cap_data));
endmodule

// File: rtl/tct_stall.sv
module tct_stall #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] len,
   output logic             busy,
   output logic             done
);
   logic [CNT_W-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         done   <= 1'b0;
         remain <= '0;
      end else begin
         done <= 1'b0;
         if (busy) begin
            remain <= remain - CNT_W'(1);
            if (remain == CNT_W'(1)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end else if (start) begin
            if (len == '0) begin
               done <= 1'b1;
            end else begin
               busy   <= 1'b1;
               remain <= len;
            end
         end
      end
   end

   assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_end_pulses_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);
endmodule

// File: rtl/tct_line_timer.sv
module tct_line_timer #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sched,
   input  logic             clear,
   input  logic [CNT_W-1:0] delay,
   output logic             line_n
);
   logic [CNT_W-1:0] cnt;
   logic             armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_n <= 1'b1;
         armed  <= 1'b0;
         cnt    <= '0;
      end else if (clear) begin
         line_n <= 1'b1;
         armed  <= 1'b0;
      end else if (sched) begin
         if (delay == '0) begin
            line_n <= 1'b0;
            armed  <= 1'b0;
         end else begin
            cnt   <= delay;
            armed <= 1'b1;
         end
      end else if (armed) begin
         if (cnt == CNT_W'(1)) begin
            line_n <= 1'b0;
            armed  <= 1'b0;
         end else begin
            cnt <= cnt - CNT_W'(1);
         end
      end
   end

   assert_release_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> line_n);

   assert_fall_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(line_n) |-> $past(!clear && ((sched && delay == '0) ||
                                         (!sched && armed && cnt == CNT_W'(1)))));
endmodule

// File: rtl/timed_test_copro.sv
module timed_test_copro #(
   parameter int DATA_W = 32,
   parameter int NREG   = 16
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [tct_pkg::INSTR_W-1:0]    op_instr,
   input  logic                           mv_to_valid,
   input  logic [DATA_W-1:0]              mv_wdata,
   input  logic                           cmd_valid,
   output logic [DATA_W-1:0]              mv_rdata,
   output logic                           busy,
   output logic                           done,
   output logic                           refused,
   output logic                           fiq_n,
   output logic                           irq_n
);
   import tct_pkg::*;

   localparam int IDX_W  = $clog2(NREG);
   localparam int NLINES = 2;

   if (IDX_W > FIELD_W || NREG != (1 << IDX_W)) begin : g_bad_nreg
      $error("NREG must be a power of two no larger than the index field");
   end
   if (DATA_W < 8) begin : g_bad_width
      $error("DATA_W too small");
   end

   logic [FIELD_W-1:0] code;
   logic [IDX_W-1:0]   mv_idx, opnd_idx;
   logic [DATA_W-1:0]  opnd_val, cyc;
   logic               accept, legal, stall_done, ack_r;
   logic [NLINES-1:0]  lines_n;
   logic               unused_fields;

   assign code     = op_instr[CODE_LSB +: FIELD_W];
   assign mv_idx   = op_instr[MOVE_LSB +: IDX_W];
   assign opnd_idx = op_instr[OPND_LSB +: IDX_W];
   assign unused_fields = ^{op_instr[INSTR_W-1:CODE_LSB+FIELD_W],
                            op_instr[MOVE_LSB-1:OPND_LSB+FIELD_W]};

   assign accept = cmd_valid && !busy;
   assign legal  = (code <= OP_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cyc <= '0;
      else        cyc <= cyc + DATA_W'(1);
   end

   tct_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .mv_we    (mv_to_valid),
      .mv_idx   (mv_idx),
      .mv_data  (mv_wdata),
      .cap_we   (accept && code == OP_STAMP),
      .cap_idx  (opnd_idx),
      .cap_data (cyc),
      .rd_a_idx (mv_idx),
      .rd_a     (mv_rdata),
      .rd_b_idx (opnd_idx),
      .rd_b     (opnd_val)
   );

   tct_stall #(.CNT_W(DATA_W)) u_stall (
      .clk   (clk),
      .rst_n (rst_n),
      .start (accept && code == OP_STALL),
      .len   (opnd_val),
      .busy  (busy),
      .done  (stall_done)
   );

   for (genvar k = 0; k < NLINES; k++) begin : g_line
      localparam logic [FIELD_W-1:0] SET_C = (k == 0) ? OP_SET_FAST : OP_SET_NORM;
      localparam logic [FIELD_W-1:0] CLR_C = (k == 0) ? OP_CLR_FAST : OP_CLR_NORM;
      tct_line_timer #(.CNT_W(DATA_W)) u_timer (
         .clk    (clk),
         .rst_n  (rst_n),
         .sched  (accept && code == SET_C),
         .clear  (accept && code == CLR_C),
         .delay  (opnd_val),
         .line_n (lines_n[k])
      );
   end

   assign fiq_n = lines_n[0];
   assign irq_n = lines_n[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_r   <= 1'b0;
         refused <= 1'b0;
      end else begin
         ack_r   <= accept && legal && code != OP_STALL;
         refused <= accept && !legal;
      end
   end

   assign done = stall_done | ack_r;

   assert_cycle_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> cyc == $past(cyc) + DATA_W'(1));

   assert_refuse_no_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      refused |-> !done);

   assert_busy_ignores_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_valid) |=> !refused);

   assert_ack_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(stall_done && ack_r));
endmodule

// File: tb/timed_test_copro_test.sv
module timed_test_copro_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] instr = '0;
   logic        mv_to = 1'b0;
   logic        cmd = 1'b0;
   logic [31:0] wdata = '0;
   wire  [31:0] rdata;
   wire         busy, done, refused, fiq_n, irq_n;

   int          n_cmp = 0;
   int          n_bad = 0;
   bit          finished = 1'b0;
   int unsigned tcnt;

   always #2 clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n) tcnt <= 0;
      else        tcnt <= tcnt + 1;
   end

   timed_test_copro uut (
      .clk(clk), .rst_n(rst_n), .op_instr(instr), .mv_to_valid(mv_to),
      .mv_wdata(wdata), .cmd_valid(cmd), .mv_rdata(rdata), .busy(busy),
      .done(done), .refused(refused), .fiq_n(fiq_n), .irq_n(irq_n));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic mv_write(input int idx, input logic [31:0] val);
      instr = 32'(idx) << 16;
      wdata = val;
      mv_to = 1'b1;
      @(negedge clk);
      mv_to = 1'b0;
   endtask

   task automatic rd(input int idx, output logic [31:0] val);
      instr = 32'(idx) << 16;
      #1;
      val = rdata;
   endtask

   task automatic issue(input int code, input int opnd);
      instr = (32'(code) << 20) | 32'(opnd);
      cmd = 1'b1;
      @(negedge clk);
      cmd = 1'b0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(4 * 150000);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      logic [31:0] exp0;
      int          cnt;

      // R1 reset state
      repeat (3) @(negedge clk);
      chk("R1 busy", {31'd0, busy}, 32'd0);
      chk("R1 fiq_n", {31'd0, fiq_n}, 32'd1);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 done", {31'd0, done}, 32'd0);
      chk("R1 refused", {31'd0, refused}, 32'd0);
      chk("R1 irq_n", {31'd0, irq_n}, 32'd1);
      for (int i = 0; i < 16; i++) begin
         rd(i, v);
         chk("R1 reg zero", v, 32'd0);
      end
      @(negedge clk);

      // R2 move sweep
      for (int i = 0; i < 16; i++) mv_write(i, 32'hA5000000 ^ (32'(i) * 32'h01010101));
      for (int i = 0; i < 16; i++) begin
         rd(i, v);
         chk("R2 readback", v, 32'hA5000000 ^ (32'(i) * 32'h01010101));
      end
      @(negedge clk);

      // R3 stall length sweep
      for (int n = 0; n <= 6; n++) begin
         mv_write(3, 32'(n));
         issue(0, 3);
         cnt = 0;
         for (int t = 0; t < 40; t++) begin
            if (done) break;
            if (busy) cnt++;
            @(negedge clk);
         end
         chk("R3 busy cycles", 32'(cnt), 32'(n));
         chk("R3 done seen", {31'd0, done}, 32'd1);
         chk("R3 busy low at done", {31'd0, busy}, 32'd0);
         @(negedge clk);
         chk("R3 done single", {31'd0, done}, 32'd0);
      end

      // R4 / R5 / R6 / R11 delay sweep on both lines
      for (int ln = 0; ln < 2; ln++) begin
         for (int d = 0; d <= 5; d++) begin
            mv_write(5, 32'(d));
            issue(ln == 0 ? 1 : 2, 5);
            chk("R11 done after schedule", {31'd0, done}, 32'd1);
            cnt = 1;
            while (((ln == 0) ? fiq_n : irq_n) === 1'b1 && cnt < 40) begin
               @(negedge clk);
               cnt++;
            end
            chk(ln == 0 ? "R4 fast latency" : "R5 normal latency", 32'(cnt), 32'(d + 1));
            issue(ln == 0 ? 3 : 4, 0);
            chk("R6 released", {31'd0, (ln == 0) ? fiq_n : irq_n}, 32'd1);
            chk("R11 done after release", {31'd0, done}, 32'd1);
         end
      end

      // R7 overwrite of a pending delay
      mv_write(5, 32'd20);
      mv_write(6, 32'd3);
      issue(1, 5);
      @(negedge clk);
      issue(1, 6);
      cnt = 1;
      while (fiq_n === 1'b1 && cnt < 40) begin
         @(negedge clk);
         cnt++;
      end
      chk("R7 new delay rules", 32'(cnt), 32'd4);
      issue(3, 0);

      // R6 release on the expiry edge
      mv_write(6, 32'd2);
      issue(1, 6);
      @(negedge clk);
      issue(3, 0);
      for (int t = 0; t < 5; t++) begin
         chk("R6 release beats expiry", {31'd0, fiq_n}, 32'd1);
         @(negedge clk);
      end

      // R8 cycle capture
      exp0 = 32'(tcnt);
      issue(5, 7);
      chk("R11 done after capture", {31'd0, done}, 32'd1);
      rd(7, v);
      chk("R8 capture first", v, exp0);
      @(negedge clk);
      repeat (4) @(negedge clk);
      exp0 = 32'(tcnt);
      issue(5, 8);
      rd(8, v);
      chk("R8 capture second", v, exp0);
      @(negedge clk);
      // R8 capture and move to one register on one edge
      exp0 = 32'(tcnt);
      instr = (32'(5) << 20) | (32'(9) << 16) | 32'(9);
      wdata = 32'h1234_5678;
      cmd = 1'b1;
      mv_to = 1'b1;
      @(negedge clk);
      cmd = 1'b0;
      mv_to = 1'b0;
      rd(9, v);
      chk("R8 capture wins", v, exp0);
      @(negedge clk);

      // R9 refused codes
      mv_write(4, 32'd0);
      for (int c = 6; c <= 15; c++) begin
         issue(c, 4);
         chk("R9 refused pulse", {31'd0, refused}, 32'd1);
         chk("R9 no done", {31'd0, done}, 32'd0);
         @(negedge clk);
         chk("R9 refused single", {31'd0, refused}, 32'd0);
         chk("R9 lines idle", {30'd0, fiq_n, irq_n}, 32'd3);
         rd(4, v);
         chk("R9 reg untouched", v, 32'd0);
      end
      @(negedge clk);

      // R10 commands ignored while busy
      mv_write(3, 32'd8);
      issue(0, 3);
      issue(1, 4);
      chk("R10 no done while busy", {31'd0, done}, 32'd0);
      issue(12, 4);
      chk("R10 no refused while busy", {31'd0, refused}, 32'd0);
      mv_write(10, 32'hDEAD_BEEF);
      rd(10, v);
      chk("R10 move while busy", v, 32'hDEAD_BEEF);
      cnt = 0;
      while (!done && cnt < 40) begin
         @(negedge clk);
         cnt++;
      end
      chk("R10 stall completes", {31'd0, done}, 32'd1);
      repeat (3) @(negedge clk);
      chk("R10 fast line untouched", {31'd0, fiq_n}, 32'd1);

      finish_run();
   end
endmodule